// File: doc/BRIEF.md
# Feedback ALU Datapath

This block is a 16-bit arithmetic and logic datapath whose registered result can be routed straight back into its own operands. Each of the two ALU operands passes through a 2:1 selector. The selector chooses between an operand supplied from outside and the value currently held in the result register. The ALU applies one of four operations, chosen by a 2-bit code, and the outcome is stored on the next rising clock edge.

Chained computations use the feedback selectors. Accumulation, repeated masking or repeated subtraction can run for several cycles without the result ever leaving the block, on either operand or both. Every input is expected to change only in step with the rising edge. The register-to-register loop runs from the result register, through a selector and the ALU, back to the register input. It must settle within one clock period less the register setup time.

Top module: `fbk_alu_path`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q` becomes 0 after that edge, whatever the other inputs are (synchronous, active-high reset that overrides the operation).
- R2: With `op_sel` = 2'b00 the register captures operand A plus operand B, with the carry out dropped (modulo 2^16), so 16'hFFFF + 16'h0001 gives 16'h0000.
- R3: With `op_sel` = 2'b01 the register captures operand A minus operand B modulo 2^16, so 16'h0000 - 16'h0001 gives 16'hFFFF.
- R4: With `op_sel` = 2'b10 the register captures the bitwise AND of the operands.
- R5: With `op_sel` = 2'b11 the register captures the bitwise OR of the operands.
- R6: Operand A is `ext_a` when `a_from_res` is 0 and the current `res_q` when `a_from_res` is 1.
- R7: Operand B is `ext_b` when `b_from_res` is 0 and the current `res_q` when `b_from_res` is 1.
- R8: With both selects at 1 the same register value feeds both operands: AND and OR leave `res_q` unchanged, subtraction yields 0, and addition doubles it modulo 2^16.
- R9: `res_q` changes only at a rising edge. Inputs applied between edges do not show on `res_q` until the next rising edge, which captures the operation of the inputs present just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result is captured on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| ext_a | input | 16 | External value for operand A |
| ext_b | input | 16 | External value for operand B |
| a_from_res | input | 1 | 1 routes the registered result to operand A, 0 routes `ext_a` |
| b_from_res | input | 1 | 1 routes the registered result to operand B, 0 routes `ext_b` |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 AND, 11 OR |
| res_q | output | 16 | Registered ALU result |

## Verification
Each operation first runs on external operands with alternating bit patterns and carry-heavy values. These show whether the four operations are decoded in the right order, and the wrap cases (all ones plus one, zero minus one) reveal a carry or borrow that leaks out. Feedback is then tried on one side at a time with a non-symmetric operation (subtraction), so a swapped or stuck selector gives a different value. A chain with both selects at 1 (doubling, self-AND, self-OR, self-subtract) shows whether both operands really take the register. Random mixes of all selects follow. A reset applied in the middle of activity and a mid-cycle input change confirm reset priority and edge-only updates.

// File: rtl/fbk_alu_pkg.sv
package fbk_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/fbk_operand_mux.sv
module fbk_operand_mux #(
  parameter int W = 16
) (
  input  logic [W-1:0] ext_i,
  input  logic [W-1:0] fbk_i,
  input  logic         use_fbk_i,
  output logic [W-1:0] opnd_o
);
  always_comb begin
    if (use_fbk_i) opnd_o = fbk_i;
    else           opnd_o = ext_i;
  end
endmodule

// File: rtl/fbk_alu_core.sv
module fbk_alu_core
  import fbk_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/fbk_result_reg.sv
module fbk_result_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end

  // Reset seen at the last rising edge must leave the register cleared.
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen === 1'b1)
      AST_RST_CLEAR: assert (q_o == '0) else $error("result not cleared after reset"); // R1
  end
endmodule

// File: rtl/fbk_alu_path.sv
module fbk_alu_path
  import fbk_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ext_a,
  input  logic [W-1:0] ext_b,
  input  logic         a_from_res,
  input  logic         b_from_res,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] res_q
);
  localparam int NOPND = 2;

  logic [NOPND-1:0][W-1:0] ext_v;
  logic [NOPND-1:0]        sel_v;
  logic [NOPND-1:0][W-1:0] opnd;
  logic [W-1:0]            alu_y;

  assign ext_v = {ext_b, ext_a};
  assign sel_v = {b_from_res, a_from_res};

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    fbk_operand_mux #(.W(W)) u_mux (
      .ext_i     (ext_v[i]),
      .fbk_i     (res_q),
      .use_fbk_i (sel_v[i]),
      .opnd_o    (opnd[i])
    );
  end

  fbk_alu_core #(.W(W)) u_alu (
    .a_i  (opnd[0]),
    .b_i  (opnd[1]),
    .op_i (alu_op_e'(op_sel)),
    .y_o  (alu_y)
  );

  fbk_result_reg #(.W(W)) u_res (
    .clk (clk),
    .rst (rst),
    .d_i (alu_y),
    .q_o (res_q)
  );

  // Register contents versus the operands present one edge earlier.
  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b00) |-> res_q == W'($past(opnd[0]) + $past(opnd[1]))); // R2
  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b01) |-> res_q == W'($past(opnd[0]) - $past(opnd[1]))); // R3
  AST_AND_BITS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b10) |-> res_q == ($past(opnd[0]) & $past(opnd[1]))); // R4
  AST_OR_BITS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b11) |-> res_q == ($past(opnd[0]) | $past(opnd[1]))); // R5
  AST_A_EXT_PATH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(a_from_res) && $past(op_sel) == 2'b10 && $past(ext_b) == '1)
      |-> res_q == $past(ext_a) || $past(b_from_res)); // R6
  AST_SELF_LOGIC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_from_res) && $past(b_from_res) && $past(op_sel[1]))
      |-> res_q == $past(res_q)); // R8
  AST_SELF_SUB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_from_res) && $past(b_from_res) && $past(op_sel) == 2'b01)
      |-> res_q == '0); // R8
endmodule

// File: tb/fbk_alu_path_tb.sv
module fbk_alu_path_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ext_a = '0;
  logic [W-1:0] ext_b = '0;
  logic         a_from_res = 1'b0;
  logic         b_from_res = 1'b0;
  logic [1:0]   op_sel = 2'b00;
  logic [W-1:0] res_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;

  fbk_alu_path #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .ext_a(ext_a), .ext_b(ext_b),
    .a_from_res(a_from_res), .b_from_res(b_from_res),
    .op_sel(op_sel), .res_q(res_q)
  );

  function automatic logic [W-1:0] ref_op(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      2'b00:   return a + b;
      2'b01:   return a - b;
      2'b10:   return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    n_chk++;
    if (res_q !== exp) begin
      n_fail++;
      $display("FAIL %s: res_q=%h expected %h", req, res_q, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(string req, logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b,
                      logic sa, logic sb);
    logic [W-1:0] oa, ob;
    ext_a = a; ext_b = b; a_from_res = sa; b_from_res = sb; op_sel = op;
    oa = sa ? model : a;
    ob = sb ? model : b;
    model = ref_op(op, oa, ob);
    @(posedge clk); @(negedge clk);
    check(req, model);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; ext_a = 16'h1234; ext_b = 16'h4321; op_sel = 2'b11;
    @(posedge clk); @(negedge clk);
    model = '0;
    check("R1 reset", '0);
    rst = 1'b0;
  endtask

  task automatic t_ops_external();
    step("R2 add",  2'b00, 16'h1234, 16'h0FED, 0, 0);
    step("R2 add",  2'b00, 16'hAAAA, 16'h5555, 0, 0);
    step("R3 sub",  2'b01, 16'h5000, 16'h1234, 0, 0);
    step("R3 sub",  2'b01, 16'h00FF, 16'hFF00, 0, 0);
    step("R4 and",  2'b10, 16'hF0F0, 16'h3C3C, 0, 0);
    step("R4 and",  2'b10, 16'hAAAA, 16'h5555, 0, 0);
    step("R5 or",   2'b11, 16'hF000, 16'h000F, 0, 0);
    step("R5 or",   2'b11, 16'hAAAA, 16'h5555, 0, 0);
  endtask

  task automatic t_wrap();
    step("R2 wrap", 2'b00, 16'hFFFF, 16'h0001, 0, 0);
    check("R2 wrap literal", 16'h0000);
    step("R3 wrap", 2'b01, 16'h0000, 16'h0001, 0, 0);
    check("R3 wrap literal", 16'hFFFF);
  endtask

  task automatic t_feedback_single();
    step("R6 seed", 2'b00, 16'h0100, 16'h0000, 0, 0);
    step("R6 a fbk sub", 2'b01, 16'hDEAD, 16'h0010, 1, 0);
    check("R6 a fbk literal", 16'h00F0);
    step("R7 b fbk sub", 2'b01, 16'h1000, 16'hBEEF, 0, 1);
    check("R7 b fbk literal", 16'h0F10);
    step("R6 a ext", 2'b11, 16'h0003, 16'h0000, 0, 0);
    step("R7 b ext", 2'b00, 16'h0000, 16'h0040, 1, 0);
    check("R7 b ext literal", 16'h0043);
  endtask

  task automatic t_feedback_both();
    step("R8 seed", 2'b00, 16'h4321, 16'h0000, 0, 0);
    step("R8 double", 2'b00, 16'h0000, 16'h0000, 1, 1);
    check("R8 double literal", 16'h8642);
    step("R8 double wrap", 2'b00, 16'hFFFF, 16'hFFFF, 1, 1);
    check("R8 double wrap literal", 16'h0C84);
    step("R8 self and", 2'b10, 16'h0000, 16'h0000, 1, 1);
    check("R8 self and literal", 16'h0C84);
    step("R8 self or", 2'b11, 16'hFFFF, 16'hFFFF, 1, 1);
    check("R8 self or literal", 16'h0C84);
    step("R8 self sub", 2'b01, 16'h1111, 16'h2222, 1, 1);
    check("R8 self sub literal", 16'h0000);
  endtask

  task automatic t_edge_only();
    step("R9 setup", 2'b00, 16'h0005, 16'h0006, 0, 0);
    ext_a = 16'h7777; ext_b = 16'h1111; op_sel = 2'b01;
    #2;
    check("R9 no change between edges", 16'h000B);
    @(posedge clk); @(negedge clk);
    model = 16'h6666;
    check("R9 captured at edge", 16'h6666);
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      step("R6 R7 random", 2'($urandom), 16'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom));
    end
  endtask

  task automatic t_reset_mid();
    step("R1 pre", 2'b11, 16'h8001, 16'h0000, 0, 0);
    t_reset();
    step("R1 after", 2'b00, 16'h0000, 16'h0002, 1, 0);
    check("R1 after literal", 16'h0002);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_ops_external();
    t_wrap();
    t_feedback_single();
    t_feedback_both();
    t_edge_only();
    t_random();
    t_reset_mid();
    finish_run();
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    finish_run();
  end
endmodule